// File: doc/BRIEF.md
# Converter Control and Conversion-Clock Unit

This block is the digital front end of a 10-bit successive-approximation converter. Software configures it through two byte-wide control registers on a simple register bus: address, write strobe, write data and a combinational read-data return. The block drives the channel-select and reference-select outputs toward the analog side. It produces a single-cycle conversion-clock enable from the system clock, using either a selectable power-of-two prescaler or an alternate internal-oscillator tick input.

A conversion starts when software writes the go bit with the converter enabled. The block then issues a one-cycle start pulse to the conversion engine. The go bit reads back as 1 until the engine reports completion. Software can abort a running conversion by writing the go bit back to 0. The captured 10-bit code is presented as a 16-bit word, either right or left justified. The whole unit runs in one clock domain, and the conversion clock is an enable, not a derived clock.

Top module: `sar_ctl_unit`

## Requirements
- R1: After a synchronous active-low reset, all implemented register bits are 0. Both registers read 0x00, the result word is 0, and chan_sel, vref_ext, adc_on, conv_start, conv_abort and conv_tick are all 0.
- R2: Control register 0 at address 0x1F has these fields: bit 7 justify (1 = right), bit 6 reference (1 = external pin), bits 4:2 channel code 0 to 7, bit 1 go and bit 0 enable. Bit 5 always reads 0. The channel, reference and enable fields drive chan_sel, vref_ext and adc_on directly.
- R3: Control register 1 at address 0x9F stores the clock-select field in bits 6:4, and every other bit reads 0. A write to any other address changes no register, and a read of any other address returns 0x00.
- R4: A write to register 0 with bit 1 = 1 and bit 0 = 1 while idle starts a conversion. conv_start is high for exactly the one cycle after the write edge, and the go bit reads 1 from that cycle on.
- R5: A write with bit 1 = 1 and bit 0 = 0 does not start a conversion. conv_start stays 0, and the go bit reads 0.
- R6: When conv_done is high at a clock edge during a conversion, the go bit reads 0 after that edge and conv_data is captured. conv_done while idle is ignored, and the result stays unchanged.
- R7: A write to register 0 during a conversion with bit 1 = 0 or bit 0 = 0 aborts it. conv_abort pulses for one cycle, the go bit reads 0, and a later conv_done leaves the result unchanged.
- R8: With justify = 1 the result word carries the code in bits 9:0. With justify = 0 it carries the code in bits 15:6. All other bits are 0, and the format follows the current justify bit.
- R9: Clock-select codes give a conv_tick period of: 000 = 2, 100 = 4, 001 = 8, 101 = 16, 010 = 32 and 110 = 64 system clocks.
- R10: Clock-select codes 011 and 111 select the internal-oscillator input. conv_tick is high in the cycle after each rc_tick cycle and never without one.
- R11: A clock-select write made during a conversion does not change the tick period until the conversion ends.
- R12: While the enable bit is 0, conv_tick stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| rc_tick | input | 1 | Single-cycle tick from the internal oscillator, synchronous to clk |
| chan_sel | output | 3 | Analog channel select |
| vref_ext | output | 1 | 1 = external reference, 0 = supply |
| adc_on | output | 1 | Converter enable |
| conv_tick | output | 1 | Single-cycle conversion-clock enable |
| conv_start | output | 1 | One-cycle start pulse to the engine |
| conv_abort | output | 1 | One-cycle abort pulse to the engine |
| conv_done | input | 1 | Engine completion strobe |
| conv_data | input | 10 | Engine result code |
| result | output | 16 | Justified result word |

## Verification
Register writes, conv_start, conv_abort and the go-bit readback all appear in the first cycle after the write edge. The bench samples them at the falling edge that follows that edge. A completion strobe shows in the go bit and the result word one edge later, and a change of justify reformats the result in the cycle after its write. Tick periods are measured between the second and third ticks after a configuration change, so the irregular first interval is never judged. An rc_tick is expected to reappear as conv_tick exactly one cycle later.

// File: rtl/sar_ctl_pkg.sv
// Shared widths and helpers for the converter control unit.
// Assumes a 3-bit clock-select code and a 3-bit channel code.
package sar_ctl_pkg;

    localparam int CH_W  = 3;
    localparam int SEL_W = 3;

    // Terminal count for a prescaler code: divisor is 2^(1 + 2*code[1:0] + code[2]).
    function automatic logic [6:0] div_last(input logic [SEL_W-1:0] code);
        int ex;
        ex = 1 + 2 * int'(code[1:0]) + int'(code[2]);
        return 7'((1 << ex) - 1);
    endfunction

    // True when the code selects the internal oscillator input instead of the prescaler.
    function automatic logic is_rc(input logic [SEL_W-1:0] code);
        return code[1:0] == 2'b11;
    endfunction

endpackage

// File: rtl/sar_ctl_regs.sv
// Control register file. Holds register 0 fields (except go) and the
// register 1 clock-select field, and decodes writes for the sequencer.
// Assumes the go/busy state lives in the sequencer and is fed back for readback.
module sar_ctl_regs
    import sar_ctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] REG0_ADDR = 8'h1F,
    parameter logic [ADDR_W-1:0] REG1_ADDR = 8'h9F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wr0,
    output logic              w_go,
    output logic              w_on,
    output logic              just_q,
    output logic              vref_q,
    output logic [CH_W-1:0]   chan_q,
    output logic              on_q,
    output logic [SEL_W-1:0]  sel_q
);

    logic wr1;
    logic unused_wbit;

    // Write decode for both registers.
    always_comb begin
        wr0  = bus_we && (bus_addr == REG0_ADDR);
        wr1  = bus_we && (bus_addr == REG1_ADDR);
        w_go = bus_wdata[1];
        w_on = bus_wdata[0];
    end

    assign unused_wbit = bus_wdata[5];

    // Register 0 stored fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            just_q <= 1'b0;
            vref_q <= 1'b0;
            chan_q <= '0;
            on_q   <= 1'b0;
        end else if (wr0) begin
            just_q <= bus_wdata[7];
            vref_q <= bus_wdata[6];
            chan_q <= bus_wdata[4:2];
            on_q   <= bus_wdata[0];
        end
    end

    // Register 1 clock-select field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr1) begin
            sel_q <= bus_wdata[6:4];
        end
    end

    // Read multiplexer; unimplemented bits and unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == REG0_ADDR) begin
            bus_rdata = {just_q, vref_q, 1'b0, chan_q, busy, on_q};
        end else if (bus_addr == REG1_ADDR) begin
            bus_rdata = {1'b0, sel_q, 4'b0000};
        end
    end

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr0 |=> $stable(chan_q) && $stable(just_q)); // R3

endmodule

// File: rtl/sar_ctl_seq.sv
// Conversion sequencer. Owns the go/busy bit, issues start and abort
// pulses, and captures the engine code on completion.
// Assumes completion has priority over a same-cycle register 0 write.
module sar_ctl_seq #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr0,
    input  logic             w_go,
    input  logic             w_on,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             busy,
    output logic             conv_start,
    output logic             conv_abort,
    output logic [RES_W-1:0] raw_q
);

    // Busy state, start/abort pulses and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            conv_start <= 1'b0;
            conv_abort <= 1'b0;
            raw_q      <= '0;
        end else begin
            conv_start <= 1'b0;
            conv_abort <= 1'b0;
            if (busy && conv_done) begin
                busy  <= 1'b0;
                raw_q <= conv_data;
            end else if (wr0) begin
                if (busy) begin
                    if (!w_go || !w_on) begin
                        busy       <= 1'b0;
                        conv_abort <= 1'b1;
                    end
                end else if (w_go && w_on) begin
                    busy       <= 1'b1;
                    conv_start <= 1'b1;
                end
            end
        end
    end

    AST_GO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && conv_done |=> !busy); // R6

    AST_START_SETS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy); // R4

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(raw_q)); // R7

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> !busy && !conv_start); // R7

endmodule

// File: rtl/sar_ctl_clkgen.sv
// Conversion-clock enable generator. Divides the system clock by the
// selected power of two, or forwards the internal oscillator tick.
// Assumes rc_tick is already synchronous to clk; the select is frozen while busy.
module sar_ctl_clkgen
    import sar_ctl_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on,
    input  logic             busy,
    input  logic             start,
    input  logic [SEL_W-1:0] sel,
    input  logic             rc_tick,
    output logic             conv_tick
);

    logic [SEL_W-1:0] eff_sel;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             rc_mode;
    logic             wrap;

    // Effective select follows the register only while no conversion runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_sel <= '0;
        end else if (!busy) begin
            eff_sel <= sel;
        end
    end

    // Terminal count and mode for the effective select.
    always_comb begin
        last    = CNT_W'(div_last(eff_sel));
        rc_mode = is_rc(eff_sel);
        wrap    = (cnt >= last);
    end

    // Prescaler counter; restarts on enable-off, conversion start or oscillator mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !on || start || rc_mode) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Registered single-cycle tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_tick <= 1'b0;
        end else begin
            conv_tick <= on && (rc_mode ? rc_tick : wrap);
        end
    end

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(eff_sel)); // R11

    AST_RC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rc_mode && $past(rc_mode) && !$past(rc_tick) |-> !conv_tick); // R10

endmodule

// File: rtl/sar_ctl_unit.sv
// Top of the converter control unit: register file, sequencer, clock
// enable generator and result justification.
// Assumes a single clock domain and a synchronous active-low reset.
module sar_ctl_unit
    import sar_ctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int RES_W  = 10,
    parameter int OUT_W  = 16,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rc_tick,
    output logic [CH_W-1:0]   chan_sel,
    output logic              vref_ext,
    output logic              adc_on,
    output logic              conv_tick,
    output logic              conv_start,
    output logic              conv_abort,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    output logic [OUT_W-1:0]  result
);

    localparam int PAD_W = OUT_W - RES_W;

    logic             wr0, w_go, w_on, busy, just_q;
    logic [SEL_W-1:0] sel_q;
    logic [RES_W-1:0] raw_q;

    sar_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .busy(busy), .bus_rdata(bus_rdata),
        .wr0(wr0), .w_go(w_go), .w_on(w_on), .just_q(just_q),
        .vref_q(vref_ext), .chan_q(chan_sel), .on_q(adc_on), .sel_q(sel_q)
    );

    sar_ctl_seq #(.RES_W(RES_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr0(wr0), .w_go(w_go), .w_on(w_on),
        .conv_done(conv_done), .conv_data(conv_data), .busy(busy),
        .conv_start(conv_start), .conv_abort(conv_abort), .raw_q(raw_q)
    );

    sar_ctl_clkgen #(.CNT_W(CNT_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .on(adc_on), .busy(busy),
        .start(conv_start), .sel(sel_q), .rc_tick(rc_tick),
        .conv_tick(conv_tick)
    );

    // Justify the captured code per the current justify bit.
    always_comb begin
        if (just_q) begin
            result = {{PAD_W{1'b0}}, raw_q};
        end else begin
            result = {raw_q, {PAD_W{1'b0}}};
        end
    end

    AST_START_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> adc_on); // R5

    AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_on && !$past(adc_on) |-> !conv_tick); // R12

endmodule

// File: tb/sar_ctl_unit_test.sv
module sar_ctl_unit_test;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  bus_addr = 0;
    logic        bus_we = 0;
    logic [7:0]  bus_wdata = 0;
    logic [7:0]  bus_rdata;
    logic        rc_tick = 0;
    logic [2:0]  chan_sel;
    logic        vref_ext, adc_on, conv_tick, conv_start, conv_abort;
    logic        conv_done = 0;
    logic [9:0]  conv_data = 0;
    logic [15:0] result;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sar_ctl_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rc_tick(rc_tick),
        .chan_sel(chan_sel), .vref_ext(vref_ext), .adc_on(adc_on),
        .conv_tick(conv_tick), .conv_start(conv_start), .conv_abort(conv_abort),
        .conv_done(conv_done), .conv_data(conv_data), .result(result)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic done_pulse(input logic [9:0] d);
        @(negedge clk);
        conv_done = 1; conv_data = d;
        @(negedge clk);
        conv_done = 0;
    endtask

    // Returns the interval between the second and third ticks, or -1.
    task automatic measure(output int per);
        int seen = 0, n = 0, t2 = 0;
        per = -1;
        while (n < 800 && seen < 3) begin
            @(negedge clk);
            n++;
            if (conv_tick) begin
                seen++;
                if (seen == 2) t2 = n;
                if (seen == 3) per = n - t2;
            end
        end
    endtask

    function automatic int fmt(input int d, input int j);
        return j ? d : (d << 6);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v, p, ticks;
        repeat (5) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        @(negedge clk);
        rd(8'h1F, v); chk("R1 reg0", v, 0);
        rd(8'h9F, v); chk("R1 reg1", v, 0);
        chk("R1 result", int'(result), 0);
        chk("R1 outs", int'({chan_sel, vref_ext, adc_on, conv_start, conv_abort}), 0);
        ticks = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); ticks += int'(conv_tick); end
        chk("R12 off no tick", ticks, 0);

        // R2 field sweep, bit5 written 1 must read 0
        for (int ch = 0; ch < 8; ch++) begin
            for (int jv = 0; jv < 4; jv++) begin
                wr(8'h1F, 8'((jv << 6) | 32 | (ch << 2)));
                rd(8'h1F, v); chk("R2 readback", v, (jv << 6) | (ch << 2));
                chk("R2 chan_sel", int'(chan_sel), ch);
                chk("R2 vref_ext", int'(vref_ext), jv & 1);
            end
        end
        wr(8'h1F, 8'h01);
        chk("R2 adc_on", int'(adc_on), 1);

        // R3 register 1 and unmapped address
        wr(8'h9F, 8'hFF); rd(8'h9F, v); chk("R3 reg1 ff", v, 8'h70);
        wr(8'h9F, 8'h8F); rd(8'h9F, v); chk("R3 reg1 8f", v, 0);
        wr(8'h55, 8'hFF);
        rd(8'h1F, v); chk("R3 unmapped w reg0", v, 8'h01);
        rd(8'h9F, v); chk("R3 unmapped w reg1", v, 0);
        rd(8'h55, v); chk("R3 unmapped read", v, 0);

        // R5 go with enable off
        wr(8'h1F, 8'h02);
        chk("R5 no start", int'(conv_start), 0);
        rd(8'h1F, v); chk("R5 go reads 0", v, 0);
        @(negedge clk); chk("R5 still no start", int'(conv_start), 0);

        // R4 / R6 start and complete
        wr(8'h1F, 8'h83);
        chk("R4 start pulse", int'(conv_start), 1);
        rd(8'h1F, v); chk("R4 go set", v, 8'h83);
        @(negedge clk);
        chk("R4 start one cycle", int'(conv_start), 0);
        rd(8'h1F, v); chk("R4 go holds", v, 8'h83);
        done_pulse(10'h2A5);
        rd(8'h1F, v); chk("R6 go cleared", v, 8'h81);
        chk("R6 captured", int'(result), 16'h02A5);
        done_pulse(10'h111);
        chk("R6 idle done ignored", int'(result), 16'h02A5);

        // R8 justification sweep
        for (int i = 0; i < 16; i++) begin
            int d;
            if (i < 10) d = 1 << i;
            else if (i == 10) d = 0;
            else if (i == 11) d = 10'h3FF;
            else d = (i * 16'h9B) & 10'h3FF;
            wr(8'h1F, 8'(((i & 1) << 7) | 3));
            done_pulse(10'(d));
            chk("R8 format", int'(result), fmt(d, i & 1));
            wr(8'h1F, 8'((((i + 1) & 1) << 7) | 1));
            chk("R8 reformat", int'(result), fmt(d, (i + 1) & 1));
        end

        // R7 abort by clearing go, then by clearing enable
        wr(8'h1F, 8'h83);
        wr(8'h1F, 8'h81);
        chk("R7 abort pulse", int'(conv_abort), 1);
        rd(8'h1F, v); chk("R7 go cleared", v, 8'h81);
        done_pulse(10'h0F0);
        chk("R7 result kept", int'(result), fmt(((15 * 16'h9B) & 10'h3FF), 1));
        wr(8'h1F, 8'h83);
        wr(8'h1F, 8'h82);
        chk("R7 abort by off", int'(conv_abort), 1);
        rd(8'h1F, v); chk("R7 off go cleared", v, 8'h80);
        wr(8'h1F, 8'h81);

        // R9 divider encodings
        for (int c = 0; c < 8; c++) begin
            if ((c & 3) != 3) begin
                wr(8'h9F, 8'(c << 4));
                measure(p);
                chk("R9 period", p, 1 << (1 + 2 * (c & 3) + (c >> 2)));
            end
        end

        // R10 oscillator input codes
        for (int c = 3; c < 8; c += 4) begin
            wr(8'h9F, 8'(c << 4));
            ticks = 0;
            for (int i = 0; i < 100; i++) begin @(negedge clk); ticks += int'(conv_tick); end
            chk("R10 quiet", ticks, 0);
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); rc_tick = 1;
                @(negedge clk); rc_tick = 0;
                chk("R10 follows rc", int'(conv_tick), 1);
                @(negedge clk);
                chk("R10 single", int'(conv_tick), 0);
            end
        end

        // R11 deferred select
        wr(8'h9F, 8'h00);
        repeat (4) @(negedge clk);
        wr(8'h1F, 8'h83);
        wr(8'h9F, 8'h60);
        measure(p); chk("R11 old period while busy", p, 2);
        done_pulse(10'h123);
        measure(p); chk("R11 new period after", p, 64);

        // R12 enable off with prescaler and oscillator modes
        wr(8'h9F, 8'h00);
        wr(8'h1F, 8'h80);
        ticks = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); ticks += int'(conv_tick); end
        chk("R12 prescaler off", ticks, 0);
        wr(8'h9F, 8'h30);
        ticks = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); rc_tick = i[0];
            ticks += int'(conv_tick);
        end
        rc_tick = 0;
        chk("R12 rc off", ticks, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule